// File: doc/BRIEF.md
# Timer Compare Channel Bank

This block holds four output-compare channels that watch a free-running 31-bit time counter kept elsewhere on the chip. Each channel stores a compare target. When the counter reaches that target on a counter update, the channel raises its flag. It can also raise an interrupt and drive an action on its own output pin: either toggle the pin or send a one-cycle high pulse. A flag is cleared by writing a one to it. A global status word shows all four flags together.

The compare target is double-buffered so that a steady pulse-per-second stream can run without gaps. Software first programs a target with the channel disabled, which loads the active compare directly. It then enables the channel. From then on, each compare write is queued and only takes effect when the current match has happened. Software therefore always writes the target for the match after next. If no target is queued when a match occurs, the channel keeps its target, and the next event comes one full counter wrap later.

The register bus is a simple single-cycle write strobe with a combinational read port. Channel n has a control/status word at byte address 0x608 + 8n and a compare word at 0x60C + 8n. The global status word is at 0x604.

Top module: `cmp_channel_bank`

## Requirements
- R1: On reset all channel state is cleared: every register reads 0, all four pins are low and the interrupt is low.
- R2: The control/status word holds a stored DMA-request-enable bit at bit 0, a 4-bit mode at bits 5:2 and an interrupt-enable bit at bit 6, and each reads back as written. Bit 1 reads 0.
- R3: A compare write while the channel mode is 0 loads the active target directly. Reading the compare word returns the active target.
- R4: When the mode is non-zero, a counter update (tick) that carries a value equal to the active target sets the flag at bit 7 of that channel's word one cycle later. The global status word (0x604) shows flag n in bit n for n = 0..3.
- R5: Writing 1 to bit 7 clears the flag and writing 0 leaves it unchanged. A match in the same cycle wins over the clear.
- R6: The interrupt output is high while any channel has both its flag and its interrupt enable set.
- R7: In mode 0x5 the channel pin toggles on each match.
- R8: In mode 0xF the channel pin is high for exactly the one clock cycle after a match.
- R9: A compare write while the mode is non-zero is queued. It becomes the active target at the next match, and until then the compare word still reads the old target.
- R10: On a match with nothing queued, the active target is kept. It matches again only when the counter comes back to that value.
- R11: In mode 0 a channel never matches, and its pin stays low. Writing mode 0 discards any queued target.
- R12: Compare values are kept modulo 2^31: bit 31 of a written value is dropped, and targets past the wrap point are matched normally.
- R13: With the tick low, a counter value equal to the target causes no match.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| count_i | input | 31 | Current time counter value |
| tick_i | input | 1 | High in a cycle where count_i carries a fresh counter value |
| bus_wr_i | input | 1 | Register write strobe |
| bus_addr_i | input | 12 | Register byte address |
| bus_wdata_i | input | 32 | Register write data |
| bus_rdata_o | output | 32 | Register read data for bus_addr_i (combinational) |
| pin_o | output | 4 | Per-channel output pin |
| irq_o | output | 1 | Combined channel interrupt |

## Verification
Register writes take effect at the clock edge that samples the strobe, and reads are combinational, so every readback is checked in the low phase after that edge. A match is detected at the edge that samples the tick. The flag, the interrupt, the toggled pin, the pulse and the compare reload all appear at that same edge, so the bench samples them at the next falling edge. The pulse is then checked once more one cycle later to confirm it is low again. Counter steps keep the tick high for exactly one edge, and all checks fall between edges.

// File: rtl/cmp_pkg.sv
package cmp_pkg;

  localparam int unsigned CMP_N_CH    = 4;
  localparam int unsigned CMP_CNT_W   = 31;
  localparam int unsigned CMP_DATA_W  = 32;
  localparam int unsigned CMP_ADDR_W  = 12;
  localparam int unsigned CMP_MODE_W  = 4;

  localparam logic [CMP_MODE_W-1:0] MODE_OFF    = 4'h0;
  localparam logic [CMP_MODE_W-1:0] MODE_TOGGLE = 4'h5;
  localparam logic [CMP_MODE_W-1:0] MODE_PULSE  = 4'hF;

  // control/status byte: bit7 flag, bit6 irq enable, bits5:2 mode,
  // bit1 reserved (reads 0), bit0 DMA request enable
  typedef struct packed {
    logic                  flag;
    logic                  ie;
    logic [CMP_MODE_W-1:0] mode;
    logic                  rsv;
    logic                  dre;
  } chan_ctrl_t;

  localparam int unsigned CTRL_W = $bits(chan_ctrl_t);

endpackage

// File: rtl/cmp_reset_sync.sv
module cmp_reset_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_sync_n = sync_q[1];

endmodule

// File: rtl/cmp_bus_decode.sv
module cmp_bus_decode #(
  parameter int unsigned N_CH      = 4,
  parameter int unsigned CNT_W     = 31,
  parameter int unsigned ADDR_W    = 12,
  parameter int unsigned DATA_W    = 32,
  parameter int unsigned CTRL_W    = 8,
  parameter int unsigned CH_BASE   = 32'h608,
  parameter int unsigned CH_STRIDE = 8,
  parameter int unsigned GSR_ADDR  = 32'h604
) (
  input  logic                          bus_wr_i,
  input  logic [ADDR_W-1:0]             bus_addr_i,
  input  logic [N_CH-1:0][CTRL_W-1:0]   ctrl_rd_i,
  input  logic [N_CH-1:0][CNT_W-1:0]    cmp_rd_i,
  input  logic [N_CH-1:0]               flag_i,
  output logic [N_CH-1:0]               ctrl_we_o,
  output logic [N_CH-1:0]               cmp_we_o,
  output logic [DATA_W-1:0]             rdata_o
);

  localparam int unsigned STRIDE_LG = $clog2(CH_STRIDE);
  localparam int unsigned SLOT_W    = ADDR_W - STRIDE_LG;
  localparam logic [ADDR_W-1:0] BASE_A = ADDR_W'(CH_BASE);
  localparam logic [ADDR_W-1:0] SPAN_A = ADDR_W'(N_CH * CH_STRIDE);
  localparam logic [ADDR_W-1:0] GSR_A  = ADDR_W'(GSR_ADDR);

  logic [ADDR_W-1:0] off;
  logic              in_range;
  logic              is_cmp;
  logic [N_CH-1:0]   slot_hit;

  assign off      = bus_addr_i - BASE_A;
  assign in_range = (bus_addr_i >= BASE_A) && (off < SPAN_A) &&
                    (off[STRIDE_LG-2:0] == '0);
  assign is_cmp   = off[STRIDE_LG-1];

  for (genvar g = 0; g < N_CH; g++) begin : g_slot
    assign slot_hit[g]  = in_range && (off[ADDR_W-1:STRIDE_LG] == SLOT_W'(g));
    assign ctrl_we_o[g] = bus_wr_i && slot_hit[g] && !is_cmp;
    assign cmp_we_o[g]  = bus_wr_i && slot_hit[g] &&  is_cmp;
  end

  always_comb begin
    rdata_o = '0;
    if (bus_addr_i == GSR_A) begin
      rdata_o[N_CH-1:0] = flag_i;
    end
    for (int i = 0; i < N_CH; i++) begin
      if (slot_hit[i]) begin
        if (is_cmp) rdata_o[CNT_W-1:0]  = cmp_rd_i[i];
        else        rdata_o[CTRL_W-1:0] = ctrl_rd_i[i];
      end
    end
  end

endmodule

// File: rtl/cmp_channel.sv
module cmp_channel
  import cmp_pkg::*;
#(
  parameter int unsigned CNT_W = 31
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] count_i,
  input  logic             tick_i,
  input  logic             ctrl_we_i,
  input  logic             cmp_we_i,
  input  logic [CTRL_W-1:0] ctrl_wdata_i,
  input  logic [CNT_W-1:0] cmp_wdata_i,
  output chan_ctrl_t       ctrl_o,
  output logic [CNT_W-1:0] active_o,
  output logic             nvld_o,
  output logic             pin_o,
  output logic             irq_o
);

  chan_ctrl_t       ctrl_q,   ctrl_d;
  logic [CNT_W-1:0] active_q, active_d;
  logic [CNT_W-1:0] next_q,   next_d;
  logic             nvld_q,   nvld_d;
  logic             tog_q,    tog_d;
  logic             pulse_q,  pulse_d;
  logic             armed;
  logic             match;
  logic             ctrl_en;
  logic             cmp_en;
  logic             pin_en;
  chan_ctrl_t       wr_ctrl;
  logic             unused_rsv;

  assign wr_ctrl    = chan_ctrl_t'(ctrl_wdata_i);
  assign unused_rsv = wr_ctrl.rsv;
  assign armed      = (ctrl_q.mode != MODE_OFF);
  assign match      = tick_i && armed && (count_i == active_q);

  // control/status next state
  always_comb begin
    ctrl_d = ctrl_q;
    if (ctrl_we_i) begin
      ctrl_d.dre  = wr_ctrl.dre;
      ctrl_d.mode = wr_ctrl.mode;
      ctrl_d.ie   = wr_ctrl.ie;
      if (wr_ctrl.flag) ctrl_d.flag = 1'b0;
    end
    if (match) ctrl_d.flag = 1'b1;
    ctrl_d.rsv = 1'b0;
  end

  // double-buffered compare next state
  always_comb begin
    active_d = active_q;
    next_d   = next_q;
    nvld_d   = nvld_q;
    if (match && nvld_q) begin
      active_d = next_q;
      nvld_d   = 1'b0;
    end
    if (cmp_we_i) begin
      if (!armed) begin
        active_d = cmp_wdata_i;
        nvld_d   = 1'b0;
      end else begin
        next_d = cmp_wdata_i;
        nvld_d = 1'b1;
      end
    end
    if (ctrl_we_i && (wr_ctrl.mode == MODE_OFF)) nvld_d = 1'b0;
  end

  // pin action next state
  always_comb begin
    tog_d   = tog_q;
    pulse_d = match && (ctrl_q.mode == MODE_PULSE);
    if (match && (ctrl_q.mode == MODE_TOGGLE)) tog_d = ~tog_q;
    if (ctrl_d.mode != MODE_TOGGLE) tog_d = 1'b0;
    if (ctrl_d.mode == MODE_OFF) pulse_d = 1'b0;
  end

  assign ctrl_en = ctrl_we_i || match;
  assign cmp_en  = cmp_we_i || match || ctrl_we_i;
  assign pin_en  = ctrl_we_i || match || pulse_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
    end else if (ctrl_en) begin
      ctrl_q <= ctrl_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= '0;
      next_q   <= '0;
      nvld_q   <= 1'b0;
    end else if (cmp_en) begin
      active_q <= active_d;
      next_q   <= next_d;
      nvld_q   <= nvld_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tog_q   <= 1'b0;
      pulse_q <= 1'b0;
    end else if (pin_en) begin
      tog_q   <= tog_d;
      pulse_q <= pulse_d;
    end
  end

  assign ctrl_o   = ctrl_q;
  assign active_o = active_q;
  assign nvld_o   = nvld_q;
  assign pin_o    = tog_q | pulse_q;
  assign irq_o    = ctrl_q.flag & ctrl_q.ie;

endmodule

// File: rtl/cmp_channel_bank.sv
module cmp_channel_bank
  import cmp_pkg::*;
#(
  parameter int unsigned N_CH      = CMP_N_CH,
  parameter int unsigned CNT_W     = CMP_CNT_W,
  parameter int unsigned ADDR_W    = CMP_ADDR_W,
  parameter int unsigned DATA_W    = CMP_DATA_W,
  parameter int unsigned CH_BASE   = 32'h608,
  parameter int unsigned CH_STRIDE = 8,
  parameter int unsigned GSR_ADDR  = 32'h604
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CNT_W-1:0]  count_i,
  input  logic              tick_i,
  input  logic              bus_wr_i,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic [DATA_W-1:0] bus_wdata_i,
  output logic [DATA_W-1:0] bus_rdata_o,
  output logic [N_CH-1:0]   pin_o,
  output logic              irq_o
);

  logic                            rst_sync_n;
  logic [N_CH-1:0]                 ctrl_we;
  logic [N_CH-1:0]                 cmp_we;
  logic [N_CH-1:0][CTRL_W-1:0]     ctrl_rd;
  logic [N_CH-1:0][CNT_W-1:0]      active_arr;
  logic [N_CH-1:0][CMP_MODE_W-1:0] mode_arr;
  logic [N_CH-1:0]                 flag_vec;
  logic [N_CH-1:0]                 ie_vec;
  logic [N_CH-1:0]                 nvld_vec;
  logic [N_CH-1:0]                 ch_irq;
  logic                            unused_wdata_hi;

  assign unused_wdata_hi = ^bus_wdata_i[DATA_W-1:CNT_W];

  cmp_reset_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  cmp_bus_decode #(
    .N_CH      (N_CH),
    .CNT_W     (CNT_W),
    .ADDR_W    (ADDR_W),
    .DATA_W    (DATA_W),
    .CTRL_W    (CTRL_W),
    .CH_BASE   (CH_BASE),
    .CH_STRIDE (CH_STRIDE),
    .GSR_ADDR  (GSR_ADDR)
  ) u_dec (
    .bus_wr_i   (bus_wr_i),
    .bus_addr_i (bus_addr_i),
    .ctrl_rd_i  (ctrl_rd),
    .cmp_rd_i   (active_arr),
    .flag_i     (flag_vec),
    .ctrl_we_o  (ctrl_we),
    .cmp_we_o   (cmp_we),
    .rdata_o    (bus_rdata_o)
  );

  for (genvar g = 0; g < N_CH; g++) begin : g_ch
    chan_ctrl_t ctrl_s;

    cmp_channel #(
      .CNT_W (CNT_W)
    ) u_ch (
      .clk          (clk),
      .rst_n        (rst_sync_n),
      .count_i      (count_i),
      .tick_i       (tick_i),
      .ctrl_we_i    (ctrl_we[g]),
      .cmp_we_i     (cmp_we[g]),
      .ctrl_wdata_i (bus_wdata_i[CTRL_W-1:0]),
      .cmp_wdata_i  (bus_wdata_i[CNT_W-1:0]),
      .ctrl_o       (ctrl_s),
      .active_o     (active_arr[g]),
      .nvld_o       (nvld_vec[g]),
      .pin_o        (pin_o[g]),
      .irq_o        (ch_irq[g])
    );

    assign ctrl_rd[g]  = ctrl_s;
    assign mode_arr[g] = ctrl_s.mode;
    assign flag_vec[g] = ctrl_s.flag;
    assign ie_vec[g]   = ctrl_s.ie;
  end

  assign irq_o = |ch_irq;

endmodule

// File: rtl/cmp_bank_chk.sv
module cmp_bank_chk #(
  parameter int unsigned N_CH  = 4,
  parameter int unsigned CNT_W = 31
) (
  input logic                  clk,
  input logic                  rst_q_n,
  input logic [CNT_W-1:0]      count_i,
  input logic                  tick_i,
  input logic [N_CH-1:0]       pin_o,
  input logic                  irq_o,
  input logic [N_CH-1:0][3:0]  mode_arr,
  input logic [N_CH-1:0]       flag_vec,
  input logic [N_CH-1:0]       ie_vec,
  input logic [N_CH-1:0]       nvld_vec,
  input logic [N_CH-1:0][CNT_W-1:0] active_arr
);

  AST_IRQ_QUIET: assert property (@(posedge clk) disable iff (!rst_q_n)
    ((flag_vec & ie_vec) == '0) |-> !irq_o);  // R6

  for (genvar g = 0; g < N_CH; g++) begin : g_chk
    AST_OFF_PIN_LOW: assert property (@(posedge clk) disable iff (!rst_q_n)
      (mode_arr[g] == 4'h0) |-> !pin_o[g]);  // R11

    AST_FLAG_FROM_MATCH: assert property (@(posedge clk) disable iff (!rst_q_n)
      $rose(flag_vec[g]) |-> $past(tick_i && (mode_arr[g] != 4'h0) &&
                                   (count_i == active_arr[g])));  // R4

    AST_RELOAD_FROM_QUEUE: assert property (@(posedge clk) disable iff (!rst_q_n)
      ($past(mode_arr[g] != 4'h0) && (active_arr[g] != $past(active_arr[g])))
        |-> $past(nvld_vec[g]));  // R9

    AST_KEEP_TARGET: assert property (@(posedge clk) disable iff (!rst_q_n)
      ($past(mode_arr[g] != 4'h0) && !$past(nvld_vec[g]))
        |-> (active_arr[g] == $past(active_arr[g])));  // R10

    AST_PULSE_NEEDS_MATCH: assert property (@(posedge clk) disable iff (!rst_q_n)
      ((mode_arr[g] == 4'hF) && $past(mode_arr[g] == 4'hF) && pin_o[g])
        |-> $past(tick_i && (count_i == active_arr[g])));  // R8

    AST_NO_TICK_NO_FLAG: assert property (@(posedge clk) disable iff (!rst_q_n)
      !$past(tick_i) |-> !$rose(flag_vec[g]));  // R13
  end

endmodule

bind cmp_channel_bank cmp_bank_chk #(.N_CH(N_CH), .CNT_W(CNT_W)) u_chk (
  .clk        (clk),
  .rst_q_n    (rst_sync_n),
  .count_i    (count_i),
  .tick_i     (tick_i),
  .pin_o      (pin_o),
  .irq_o      (irq_o),
  .mode_arr   (mode_arr),
  .flag_vec   (flag_vec),
  .ie_vec     (ie_vec),
  .nvld_vec   (nvld_vec),
  .active_arr (active_arr)
);

// File: tb/cmp_channel_bank_tb.sv
module cmp_channel_bank_tb;

  localparam int CLK_PERIOD = 10;
  localparam int WD_CYCLES  = 20000;

  // op kinds: write, read-check, counter step with tick, pins/irq check, idle
  localparam logic [2:0] OP_W = 3'd0, OP_R = 3'd1, OP_S = 3'd2,
                         OP_P = 3'd3, OP_I = 3'd4;

  typedef struct packed {
    logic [2:0]  kind;
    logic [11:0] addr;
    logic [31:0] data;
    logic [31:0] exp;
    logic [7:0]  req;
  } vec_t;

  localparam int NV = 46;
  localparam vec_t VEC [NV] = '{
    '{OP_R, 12'h608, 32'h0,        32'h0,        8'd1},  // R1
    '{OP_R, 12'h604, 32'h0,        32'h0,        8'd1},  // R1
    '{OP_W, 12'h60C, 32'd100,      32'h0,        8'd3},  // R3 direct load
    '{OP_R, 12'h60C, 32'h0,        32'd100,      8'd3},  // R3
    '{OP_W, 12'h608, 32'h55,       32'h0,        8'd2},  // R2 toggle, ie, dre
    '{OP_R, 12'h608, 32'h0,        32'h55,       8'd2},  // R2
    '{OP_W, 12'h60C, 32'd200,      32'h0,        8'd9},  // R9 queued
    '{OP_R, 12'h60C, 32'h0,        32'd100,      8'd9},  // R9 still old
    '{OP_S, 12'h0,   32'd99,       32'h0,        8'd4},  // R4
    '{OP_P, 12'h0,   32'h0,        32'h00,       8'd4},  // R4 no match
    '{OP_S, 12'h0,   32'd100,      32'h0,        8'd4},  // R4 match
    '{OP_R, 12'h608, 32'h0,        32'hD5,       8'd4},  // R4 flag
    '{OP_R, 12'h604, 32'h0,        32'h1,        8'd4},  // R4 global
    '{OP_P, 12'h0,   32'h0,        32'h11,       8'd6},  // R6 R7
    '{OP_R, 12'h60C, 32'h0,        32'd200,      8'd9},  // R9 reloaded
    '{OP_W, 12'h608, 32'h55,       32'h0,        8'd5},  // R5 write 0
    '{OP_R, 12'h608, 32'h0,        32'hD5,       8'd5},  // R5 kept
    '{OP_W, 12'h608, 32'hD5,       32'h0,        8'd5},  // R5 W1C
    '{OP_R, 12'h608, 32'h0,        32'h55,       8'd5},  // R5
    '{OP_P, 12'h0,   32'h0,        32'h01,       8'd6},  // R6 irq drops
    '{OP_S, 12'h0,   32'd200,      32'h0,        8'd7},  // R7
    '{OP_P, 12'h0,   32'h0,        32'h10,       8'd7},  // R7 toggled low
    '{OP_W, 12'h608, 32'hD5,       32'h0,        8'd5},  // R5
    '{OP_P, 12'h0,   32'h0,        32'h00,       8'd6},  // R6
    '{OP_S, 12'h0,   32'd300,      32'h0,        8'd10}, // R10
    '{OP_R, 12'h60C, 32'h0,        32'd200,      8'd10}, // R10 kept
    '{OP_R, 12'h608, 32'h0,        32'h55,       8'd10}, // R10 no event
    '{OP_W, 12'h614, 32'hFFFFFFFF, 32'h0,        8'd12}, // R12
    '{OP_R, 12'h614, 32'h0,        32'h7FFFFFFF, 8'd12}, // R12
    '{OP_S, 12'h0,   32'h7FFFFFFF, 32'h0,        8'd11}, // R11
    '{OP_R, 12'h610, 32'h0,        32'h0,        8'd11}, // R11
    '{OP_R, 12'h604, 32'h0,        32'h0,        8'd11}, // R11
    '{OP_P, 12'h0,   32'h0,        32'h00,       8'd11}, // R11
    '{OP_W, 12'h61C, 32'd500,      32'h0,        8'd3},  // R3
    '{OP_W, 12'h618, 32'h3C,       32'h0,        8'd8},  // R8 pulse mode
    '{OP_R, 12'h618, 32'h0,        32'h3C,       8'd2},  // R2
    '{OP_S, 12'h0,   32'd500,      32'h0,        8'd8},  // R8
    '{OP_P, 12'h0,   32'h0,        32'h04,       8'd8},  // R8 high
    '{OP_I, 12'h0,   32'h0,        32'h0,        8'd8},  // R8
    '{OP_P, 12'h0,   32'h0,        32'h00,       8'd8},  // R8 low again
    '{OP_R, 12'h604, 32'h0,        32'h4,        8'd4},  // R4
    '{OP_W, 12'h618, 32'hBC,       32'h0,        8'd5},  // R5
    '{OP_I, 12'h0,   32'h0,        32'h0,        8'd13}, // R13 count==target
    '{OP_I, 12'h0,   32'h0,        32'h0,        8'd13}, // R13
    '{OP_R, 12'h618, 32'h0,        32'h3C,       8'd13}, // R13 no flag
    '{OP_P, 12'h0,   32'h0,        32'h00,       8'd13}  // R13
  };

  logic        clk;
  logic        rst_n;
  logic [30:0] count_i;
  logic        tick_i;
  logic        bus_wr_i;
  logic [11:0] bus_addr_i;
  logic [31:0] bus_wdata_i;
  logic [31:0] bus_rdata_o;
  logic [3:0]  pin_o;
  logic        irq_o;

  int  checks;
  int  failures;
  bit  done;

  cmp_channel_bank u_dut (
    .clk         (clk),
    .rst_n       (rst_n),
    .count_i     (count_i),
    .tick_i      (tick_i),
    .bus_wr_i    (bus_wr_i),
    .bus_addr_i  (bus_addr_i),
    .bus_wdata_i (bus_wdata_i),
    .bus_rdata_o (bus_rdata_o),
    .pin_o       (pin_o),
    .irq_o       (irq_o)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input int req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL R%0d actual=0x%08h expected=0x%08h", req, act, exp);
    end
  endtask

  task automatic do_write(input logic [11:0] a, input logic [31:0] d);
    bus_addr_i  = a;
    bus_wdata_i = d;
    bus_wr_i    = 1'b1;
    @(posedge clk);
    @(negedge clk);
    bus_wr_i    = 1'b0;
  endtask

  task automatic do_read(input int req, input logic [11:0] a, input logic [31:0] e);
    bus_addr_i = a;
    #1;
    check(req, bus_rdata_o, e);
  endtask

  task automatic do_step(input logic [30:0] c);
    count_i = c;
    tick_i  = 1'b1;
    @(posedge clk);
    @(negedge clk);
    tick_i  = 1'b0;
  endtask

  task automatic do_idle();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic do_pins(input int req, input logic [4:0] e);
    #1;
    check(req, {27'd0, irq_o, pin_o}, {27'd0, e});
  endtask

  initial begin
    repeat (WD_CYCLES) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    checks = 0; failures = 0; done = 1'b0;
    rst_n = 1'b0; count_i = '0; tick_i = 1'b0;
    bus_wr_i = 1'b0; bus_addr_i = '0; bus_wdata_i = '0;
    repeat (3) @(negedge clk);
    do_pins(1, 5'h00);                       // R1 during reset
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      case (VEC[i].kind)
        OP_W:    do_write(VEC[i].addr, VEC[i].data);
        OP_R:    do_read(int'(VEC[i].req), VEC[i].addr, VEC[i].exp);
        OP_S:    do_step(VEC[i].data[30:0]);
        OP_P:    do_pins(int'(VEC[i].req), VEC[i].exp[4:0]);
        default: do_idle();
      endcase
    end

    // R10: channel 0 target 200 with empty queue fires again after a wrap
    do_step(31'd0);
    do_step(31'd199);
    do_pins(10, 5'h00);
    do_step(31'd200);
    do_read(10, 12'h608, 32'hD5);
    do_pins(10, 5'h11);

    // R1: reset in mid-run clears everything at once
    rst_n = 1'b0;
    do_pins(1, 5'h00);
    do_read(1, 12'h608, 32'h0);
    do_read(1, 12'h60C, 32'h0);
    do_read(1, 12'h614, 32'h0);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R12 with R9: queued target past the wrap point on channel 3
    do_write(12'h624, 32'h7FFFFFFE);
    do_write(12'h620, 32'h14);
    do_write(12'h624, 32'h80000003);
    do_read(12, 12'h624, 32'h7FFFFFFE);
    do_step(31'h7FFFFFFE);
    do_pins(7, 5'h08);
    do_read(12, 12'h624, 32'h3);
    do_step(31'd3);
    do_pins(12, 5'h00);
    do_read(4, 12'h620, 32'h94);

    // R11: writing mode 0 discards the queue, then a direct load
    do_write(12'h624, 32'd50);
    do_write(12'h620, 32'h80);
    do_read(11, 12'h624, 32'h3);
    do_write(12'h624, 32'd60);
    do_read(3, 12'h624, 32'd60);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule